// File: doc/BRIEF.md
# Counter-and-Tap Pulse-Width Modulator

This block produces the drive waveform for the power switch of a DC-DC converter, with an 8-bit duty word and a switching period of 16 system clocks (1 MHz at a 16 MHz clock). A plain counting modulator would need a clock 256 times the switching rate. Here the four upper duty bits are compared against a 4-bit slot counter, and the four lower bits pick one of sixteen taps of a delay chain. The chain is modelled as sixteen equally spaced sub-phases inside each clock period. The output `sw_drive` is a 16-bit word per clock. Bit k is the switch level during sub-phase k of that clock, and bit 0 is the earliest. One switching period therefore spans 256 sub-phase units.

A compensator writes `duty_in` whenever it likes. The block samples it only at the clock edge that opens a switching cycle. On that same edge it raises `cycle_start` for one clock, which asks the compensator for the next value. Inside the block a small state machine tracks the phase of the waveform:
- `PH_IDLE` holds after reset until the first cycle opens.
- `PH_DRIVE` is the set of slots before the match slot.
- `PH_EDGE` is the match slot, where the selected tap ends the pulse.
- `PH_REST` is the low remainder of the cycle.
- `PH_FULL` covers the whole cycle for the all-ones code.

Each cycle opening goes from any state to `PH_FULL` (code all ones), to `PH_EDGE` (upper bits zero) or to `PH_DRIVE` (otherwise). Inside a cycle the transitions are `PH_DRIVE`→`PH_EDGE` when the next slot equals the upper bits, `PH_EDGE`→`PH_REST`, and `PH_REST` and `PH_FULL` hold.

Top module: `hybrid_dpwm`

## Requirements
- R1: While `rst_n` is low, `sw_drive` is all zeros and `cycle_start` is low. The first cycle opens on the first rising clock edge after `rst_n` goes high, and that edge samples `duty_in`.
- R2: A cycle opens every 16 clocks. `cycle_start` is high for exactly the first clock of each cycle and low otherwise.
- R3: `duty_in` is sampled only at the edge that opens a cycle. A change at any other time, including in the last slot of a cycle, leaves the current cycle unchanged and takes effect in the next one.
- R4: For codes 1 to 254 the switch is high for exactly `code` sub-phase units. Those units are contiguous and start at sub-phase 0 of the cycle's first clock, so the pulse is set once at the cycle opening and cleared once.
- R5: Code 0 keeps `sw_drive` all zeros for the whole cycle.
- R6: Code 255 (all ones) keeps `sw_drive` all ones for all 16 clocks of the cycle, which is full duty.
- R7: In cycle slot s (0 to 15), with upper bits C = code[7:4] and lower bits F = code[3:0]: `sw_drive` is all ones when s < C, all zeros when s > C, and when s = C bit k is high exactly when k < F.
- R8: Every `sw_drive` word is thermometer-shaped: its ones form a contiguous run starting at bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, 16 per switching period |
| rst_n | input | 1 | Synchronous reset, active low |
| duty_in | input | 8 | Pending duty code from the compensator |
| sw_drive | output | 16 | Switch level for each sub-phase of the current clock, bit 0 earliest |
| cycle_start | output | 1 | One-clock strobe marking the first clock of a cycle and the sampling of `duty_in` |

## Verification
The checker assumes that `duty_in` is a settled value at every rising edge. It also assumes that the duty code the block latched is the value `duty_in` held at the edge just before `cycle_start` is seen high. This is what lets it rebuild the active code without looking inside the block. The directed stimulus changes `duty_in` only at falling edges, and it places writes deliberately in the first slot, in a middle slot and in the final slot of a cycle. This exercises the sampling rule at both ends of the period. Reset is applied once at the start with a nonzero code already present, so the first cycle after release shows whether that code is latched.

// File: rtl/dpwm_pkg.sv
package dpwm_pkg;

    // Phase of the switch waveform within one switching cycle.
    typedef enum logic [2:0] {
        PH_IDLE  = 3'd0,
        PH_DRIVE = 3'd1,
        PH_EDGE  = 3'd2,
        PH_REST  = 3'd3,
        PH_FULL  = 3'd4
    } dpwm_phase_e;

endpackage

// File: rtl/dpwm_slot_ctr.sv
// Coarse slot counter: restarts at a cycle opening and issues the strobe.
module dpwm_slot_ctr #(
    parameter int SLOT_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              restart,
    output logic [SLOT_W-1:0] slot,
    output logic              slot_last,
    output logic              start_pulse
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot        <= '0;
            start_pulse <= 1'b0;
        end else begin
            start_pulse <= restart;
            slot        <= restart ? '0 : slot + 1'b1;
        end
    end

    assign slot_last = (slot == {SLOT_W{1'b1}});

endmodule

// File: rtl/dpwm_duty_hold.sv
// Second stage of the duty buffer; loads only at a cycle opening.
module dpwm_duty_hold #(
    parameter int DUTY_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DUTY_W-1:0] duty_pending,
    output logic [DUTY_W-1:0] duty_active
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            duty_active <= '0;
        end else if (load) begin
            duty_active <= duty_pending;
        end
    end

endmodule

// File: rtl/dpwm_tap_line.sv
// Delay-chain model: tap k is still high when the selected tap lies beyond k.
module dpwm_tap_line #(
    parameter int FINE_W = 4,
    localparam int TAPS  = 1 << FINE_W
) (
    input  logic [FINE_W-1:0] tap_sel,
    output logic [TAPS-1:0]   tap_mask
);

    for (genvar k = 0; k < TAPS; k++) begin : g_tap
        localparam logic [FINE_W:0] TAP_IDX = (FINE_W + 1)'(k);
        assign tap_mask[k] = ({1'b0, tap_sel} > TAP_IDX);
    end

endmodule

// File: rtl/hybrid_dpwm.sv
module hybrid_dpwm
    import dpwm_pkg::*;
#(
    parameter int COARSE_W = 4,
    parameter int FINE_W   = 4
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [COARSE_W+FINE_W-1:0]   duty_in,
    output logic [(1<<FINE_W)-1:0]       sw_drive,
    output logic                         cycle_start
);

    localparam int DUTY_W = COARSE_W + FINE_W;
    localparam int TAPS   = 1 << FINE_W;

    dpwm_phase_e             phase_q;
    dpwm_phase_e             phase_d;
    logic [COARSE_W-1:0]     slot;
    logic [COARSE_W-1:0]     slot_nx;
    logic                    slot_last;
    logic                    open_cycle;
    logic [DUTY_W-1:0]       duty_act;
    logic [COARSE_W-1:0]     coarse_act;
    logic [FINE_W-1:0]       fine_act;
    logic [TAPS-1:0]         edge_mask;

    assign open_cycle = (phase_q == PH_IDLE) || slot_last;
    assign coarse_act = duty_act[DUTY_W-1:FINE_W];
    assign fine_act   = duty_act[FINE_W-1:0];
    assign slot_nx    = slot + 1'b1;

    dpwm_slot_ctr #(
        .SLOT_W     (COARSE_W)
    ) u_slot_ctr (
        .clk        (clk),
        .rst_n      (rst_n),
        .restart    (open_cycle),
        .slot       (slot),
        .slot_last  (slot_last),
        .start_pulse(cycle_start)
    );

    dpwm_duty_hold #(
        .DUTY_W      (DUTY_W)
    ) u_duty_hold (
        .clk         (clk),
        .rst_n       (rst_n),
        .load        (open_cycle),
        .duty_pending(duty_in),
        .duty_active (duty_act)
    );

    dpwm_tap_line #(
        .FINE_W  (FINE_W)
    ) u_tap_line (
        .tap_sel (fine_act),
        .tap_mask(edge_mask)
    );

    // Next phase
    always_comb begin
        phase_d = phase_q;
        if (open_cycle) begin
            if (duty_in == {DUTY_W{1'b1}}) begin
                phase_d = PH_FULL;
            end else if (duty_in[DUTY_W-1:FINE_W] == '0) begin
                phase_d = PH_EDGE;
            end else begin
                phase_d = PH_DRIVE;
            end
        end else begin
            unique case (phase_q)
                PH_IDLE:  phase_d = PH_IDLE;
                PH_DRIVE: phase_d = (slot_nx == coarse_act) ? PH_EDGE : PH_DRIVE;
                PH_EDGE:  phase_d = PH_REST;
                PH_REST:  phase_d = PH_REST;
                PH_FULL:  phase_d = PH_FULL;
                default:  phase_d = PH_IDLE;
            endcase
        end
    end

    // Phase register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_IDLE;
        end else begin
            phase_q <= phase_d;
        end
    end

    // Switch level per sub-phase
    always_comb begin
        unique case (phase_q)
            PH_IDLE:  sw_drive = '0;
            PH_DRIVE: sw_drive = '1;
            PH_EDGE:  sw_drive = edge_mask;
            PH_REST:  sw_drive = '0;
            PH_FULL:  sw_drive = '1;
            default:  sw_drive = '0;
        endcase
    end

endmodule

// File: rtl/dpwm_checker.sv
module dpwm_checker #(
    parameter int COARSE_W = 4,
    parameter int FINE_W   = 4
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic [COARSE_W+FINE_W-1:0] duty_in,
    input logic [(1<<FINE_W)-1:0]     sw_drive,
    input logic                       cycle_start
);

    localparam int DUTY_W = COARSE_W + FINE_W;
    localparam int TAPS   = 1 << FINE_W;
    localparam int SLOTS  = 1 << COARSE_W;

    logic [DUTY_W-1:0]   duty_prev;
    logic [DUTY_W-1:0]   code_q;
    logic                armed;
    logic [COARSE_W:0]   gap;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            duty_prev <= '0;
            code_q    <= '0;
            armed     <= 1'b0;
            gap       <= '0;
        end else begin
            duty_prev <= duty_in;
            gap       <= cycle_start ? '0 : gap + 1'b1;
            if (cycle_start) begin
                code_q <= duty_prev;
                armed  <= 1'b1;
            end
        end
    end

    assert_strobe_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cycle_start |=> !cycle_start);

    assert_period_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cycle_start && armed) |-> (gap == (COARSE_W + 1)'(SLOTS - 1)));

    assert_set_at_open_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cycle_start && duty_prev != '0) |-> sw_drive[0]);

    assert_stay_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && !cycle_start && !$past(sw_drive[TAPS-1])) |-> (sw_drive == '0));

    assert_zero_code_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ((cycle_start && duty_prev == '0) || (armed && !cycle_start && code_q == '0))
        |-> (sw_drive == '0));

    assert_full_code_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ((cycle_start && duty_prev == '1) || (armed && !cycle_start && code_q == '1))
        |-> (sw_drive == '1));

    assert_thermometer_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ((({1'b0, sw_drive} + 1'b1) & {1'b0, sw_drive}) == '0));

endmodule

bind hybrid_dpwm dpwm_checker #(
    .COARSE_W(COARSE_W),
    .FINE_W  (FINE_W)
) u_dpwm_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .duty_in    (duty_in),
    .sw_drive   (sw_drive),
    .cycle_start(cycle_start)
);

// File: tb/test_hybrid_dpwm.sv
module test_hybrid_dpwm;

    localparam int SLOTS = 16;
    localparam int TAPS  = 16;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [7:0]  duty_in;
    logic [15:0] sw_drive;
    logic        cycle_start;
    int          n_cmp = 0;
    int          n_bad = 0;
    bit          done  = 1'b0;

    always #5 clk = ~clk;

    hybrid_dpwm i_hybrid_dpwm (
        .clk        (clk),
        .rst_n      (rst_n),
        .duty_in    (duty_in),
        .sw_drive   (sw_drive),
        .cycle_start(cycle_start)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
        end
    endtask

    // Expected word from the requirements: high units H, slot s covers units 16s..16s+15.
    function automatic logic [15:0] exp_word(input int code, input int slot);
        int h;
        int n;
        logic [31:0] t;
        h = (code == 255) ? 256 : code;
        n = h - slot * TAPS;
        if (n < 0)  n = 0;
        if (n > 16) n = 16;
        t = (32'd1 << n) - 32'd1;
        return t[15:0];
    endfunction

    task automatic wait_open();
        @(negedge clk);
        while (!cycle_start) @(negedge clk);
    endtask

    // Called at the falling edge of a cycle's first clock; ends at the next one.
    task automatic measure(input int code, input int mid_slot, input int mid_code,
                           input string req);
        int ones = 0;
        int h = (code == 255) ? 256 : code;
        for (int s = 0; s < SLOTS; s++) begin
            chk(sw_drive == exp_word(code, s), req, $sformatf("R7 word slot %0d", s),
                sw_drive, exp_word(code, s));
            chk(cycle_start == (s == 0), "R2", $sformatf("strobe slot %0d", s),
                cycle_start, (s == 0));
            ones += $countones(sw_drive);
            if (s == mid_slot) duty_in = mid_code[7:0];
            @(negedge clk);
        end
        chk(ones == h, req, "high units per cycle", ones, h);
    endtask

    task automatic t_reset();
        rst_n   = 1'b0;
        duty_in = 8'h37;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            chk(sw_drive == '0, "R1", "drive in reset", sw_drive, 0);
            chk(cycle_start == 1'b0, "R1", "strobe in reset", cycle_start, 0);
        end
        rst_n = 1'b1;
        @(negedge clk);
        chk(cycle_start == 1'b1, "R1", "first strobe after release", cycle_start, 1);
        measure(8'h37, -1, 0, "R1");
    endtask

    task automatic t_code(input int code, input string req);
        duty_in = code[7:0];
        wait_open();
        measure(code, -1, 0, req);
    endtask

    task automatic t_mid_write(input int a, input int slot, input int b);
        duty_in = a[7:0];
        wait_open();
        measure(a, slot, b, "R3");
        measure(b, -1, 0, "R3");
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_code(0,   "R5");
        t_code(255, "R6");
        t_code(1,   "R4");
        t_code(16,  "R7");
        t_code(143, "R4");
        t_code(240, "R7");
        t_code(254, "R4");
        t_code(255, "R6");
        t_code(0,   "R5");
        t_mid_write(32'h20, 5, 32'hC5);
        t_mid_write(32'h48, 15, 32'h9A);
        t_mid_write(32'h9A, 0, 32'h11);
        t_mid_write(32'h00, 7, 32'hFF);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule